// File: doc/BRIEF.md
# Page Access Permission Checker

This block takes the outcome of a page-table walk and decides whether the current memory access may proceed. Its inputs are the accumulated user, writable and no-execute attributes of the translation, the leaf's dirty bit and 4-bit protection key, and the walk status (leaf present, reserved bits hit). It also takes the access type, the privilege of the requester and the paging mode controls: write protection for supervisor writes, supervisor execute prevention, no-execute enable, user and supervisor key enables, and a flag for the supervisor-access-prevention index. Two 32-bit key registers, one for user pages and one for supervisor pages, give each of the 16 keys an access-disable bit and a write-disable bit.

The block reports the read, write and execute rights of the page, with write reported as cacheable only once the page is dirty. It also reports whether the access passes or faults, and a 6-bit page-fault error code. Results are registered: a request sampled with `valid_i` high appears on the outputs on the next clock edge and stays there until the next request.

Top module: `pac_checker`

## Requirements
- R1: While `rst_ni` is low and after its release, until the first request, `valid_o`, all rights, `pass_o`, `fault_o` and `err_code_o` are 0.
- R2: Read right is set unless `sap_i` is high and the page is a user page (`acc_user_i`=1).
- R3: Write right needs the read right and additionally either `acc_rw_i`=1, or a supervisor access (`user_mode_i`=0) with `wp_i`=0.
- R4: `perm_w_o` reports the write right only when `dirty_i`=1 or the access is a write (access code 1); a write to a clean page that is otherwise allowed still passes.
- R5: Execute right is set only when `acc_nx_i`=0, and then only if `smep_i`=0, or the page is a supervisor page, or `user_mode_i`=1.
- R6: The key register is `pkr_user_i` for user pages when `pke_i`=1, `pkr_sup_i` for supervisor pages when `pks_i`=1, and zero otherwise. A zero key register disables all key checks.
- R7: For key k, bit 2k of the key register (access-disable) removes read and write. Bit 2k+1 (write-disable) removes write only when `user_mode_i`=1 or `wp_i`=1. Keys never remove execute.
- R8: Access codes are 0 read, 1 write, 2 fetch, and 3, which is treated as read. The access passes when the selected right is set and no fault applies. A user-mode access to a supervisor page always faults.
- R9: Fault priority is not-present, then reserved bits, then user-to-supervisor, then key denial, then missing right. `err_code_o` has bit0 P (all faults except not-present), bit1 W (write access), bit2 U (`user_mode_i`), bit3 RSVD (reserved fault) and bit4 I/D (fetch with `nxe_i` or `smep_i` set). It is 0 when the access passes.
- R10: A key-denied access (the key rights alone lack the selected right) faults with bit5 PK and bit0 P set.
- R11: On a not-present or reserved fault all rights read 0.
- R12: Outputs change only on a clock edge where `valid_i`=1; `valid_o` follows `valid_i` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| present_i | input | 1 | Walk reached a present leaf |
| rsvd_i | input | 1 | Walk hit reserved bits |
| acc_user_i | input | 1 | Accumulated user attribute |
| acc_rw_i | input | 1 | Accumulated writable attribute |
| acc_nx_i | input | 1 | Accumulated no-execute attribute |
| dirty_i | input | 1 | Leaf dirty bit |
| pkey_i | input | 4 | Leaf protection key |
| access_i | input | 2 | Access type code |
| user_mode_i | input | 1 | Access from user privilege |
| sap_i | input | 1 | Supervisor-access-prevention index active |
| wp_i | input | 1 | Supervisor write protection |
| smep_i | input | 1 | Supervisor execute prevention |
| nxe_i | input | 1 | No-execute enable |
| pke_i | input | 1 | User key checks enable |
| pks_i | input | 1 | Supervisor key checks enable |
| pkr_user_i | input | 32 | User key register |
| pkr_sup_i | input | 32 | Supervisor key register |
| valid_o | output | 1 | Result valid |
| perm_r_o | output | 1 | Read right |
| perm_w_o | output | 1 | Cacheable write right |
| perm_x_o | output | 1 | Execute right |
| pass_o | output | 1 | Access allowed |
| fault_o | output | 1 | Access faults |
| err_code_o | output | 6 | Page-fault error code |

## Verification
The bench sweeps every combination of attributes, access code, privilege and mode bits, with key registers from a mixing function, so each key index and each pairing of access-disable and write-disable comes up. A design that applied write-disable to supervisor accesses with write protection off would fail supervisor writes it must allow. One that forgot to treat code 3 as a read, or let keys strip execute, would flip `pass_o`. Interleaved not-present and reserved walks catch wrong fault priority or leaked rights. A wrong PK, I/D or P bit shows up in the error-code comparison. Writes to clean pages check that the write passes while later reads of the same clean page do not report a cacheable write.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam int ERR_W    = 6;
  localparam int ERR_P    = 0;
  localparam int ERR_W_B  = 1;
  localparam int ERR_U    = 2;
  localparam int ERR_RSVD = 3;
  localparam int ERR_ID   = 4;
  localparam int ERR_PK   = 5;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  function automatic logic perm_sel(perm_t p, logic [1:0] acc);
    case (acc)
      ACC_WRITE: perm_sel = p.w;
      ACC_FETCH: perm_sel = p.x;
      default:   perm_sel = p.r;
    endcase
  endfunction
endpackage

// File: rtl/pac_rights.sv
module pac_rights
  import pac_pkg::*;
(
  input  logic  user_page_i,
  input  logic  rw_i,
  input  logic  nx_i,
  input  logic  user_mode_i,
  input  logic  sap_i,
  input  logic  wp_i,
  input  logic  smep_i,
  output perm_t base_o,
  output logic  user_fault_o
);
  logic rd;
  always_comb begin
    rd            = !(sap_i && user_page_i);
    base_o.r      = rd;
    base_o.w      = rd && (rw_i || !(user_mode_i || wp_i));
    base_o.x      = !nx_i && (user_mode_i || !(smep_i && user_page_i));
    user_fault_o  = user_mode_i && !user_page_i;
  end
endmodule

// File: rtl/pac_key.sv
module pac_key
  import pac_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int PKR_W = 2 * (2 ** KEY_W),
  localparam int IDX_W = KEY_W + 1
) (
  input  logic             user_page_i,
  input  logic             pke_i,
  input  logic             pks_i,
  input  logic [PKR_W-1:0] pkr_user_i,
  input  logic [PKR_W-1:0] pkr_sup_i,
  input  logic [KEY_W-1:0] pkey_i,
  input  logic             user_mode_i,
  input  logic             wp_i,
  output logic             active_o,
  output perm_t            key_perm_o
);
  logic [PKR_W-1:0] kreg;
  logic [IDX_W-1:0] ad_idx, wd_idx;
  logic             ad, wd;

  always_comb begin
    if (user_page_i) kreg = pke_i ? pkr_user_i : '0;
    else             kreg = pks_i ? pkr_sup_i  : '0;
    ad_idx       = {pkey_i, 1'b0};
    wd_idx       = {pkey_i, 1'b1};
    ad           = kreg[ad_idx];
    wd           = kreg[wd_idx];
    active_o     = |kreg;
    key_perm_o.r = !ad;
    key_perm_o.w = !ad && !(wd && (user_mode_i || wp_i));
    key_perm_o.x = 1'b1;
  end
endmodule

// File: rtl/pac_errcode.sv
module pac_errcode
  import pac_pkg::*;
(
  input  logic             fault_i,
  input  logic             prot_i,
  input  logic             rsvd_i,
  input  logic             pk_i,
  input  logic [1:0]       access_i,
  input  logic             user_mode_i,
  input  logic             nxe_i,
  input  logic             smep_i,
  output logic [ERR_W-1:0] err_o
);
  always_comb begin
    err_o = '0;
    if (fault_i) begin
      err_o[ERR_P]    = prot_i || rsvd_i;
      err_o[ERR_W_B]  = (access_i == ACC_WRITE);
      err_o[ERR_U]    = user_mode_i;
      err_o[ERR_RSVD] = rsvd_i;
      err_o[ERR_ID]   = (access_i == ACC_FETCH) && (nxe_i || smep_i);
      err_o[ERR_PK]   = pk_i;
    end
  end
endmodule

// File: rtl/pac_checker.sv
module pac_checker
  import pac_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int PKR_W = 2 * (2 ** KEY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             present_i,
  input  logic             rsvd_i,
  input  logic             acc_user_i,
  input  logic             acc_rw_i,
  input  logic             acc_nx_i,
  input  logic             dirty_i,
  input  logic [KEY_W-1:0] pkey_i,
  input  logic [1:0]       access_i,
  input  logic             user_mode_i,
  input  logic             sap_i,
  input  logic             wp_i,
  input  logic             smep_i,
  input  logic             nxe_i,
  input  logic             pke_i,
  input  logic             pks_i,
  input  logic [PKR_W-1:0] pkr_user_i,
  input  logic [PKR_W-1:0] pkr_sup_i,
  output logic             valid_o,
  output logic             perm_r_o,
  output logic             perm_w_o,
  output logic             perm_x_o,
  output logic             pass_o,
  output logic             fault_o,
  output logic [ERR_W-1:0] err_code_o
);
  perm_t            base, kperm, comb_perm;
  logic             user_fault, key_active;
  logic             walk_ok, f_np, f_rs, f_uf, f_kd, f_pf, f_any;
  logic [ERR_W-1:0] err_d;
  logic             pw_d;

  pac_rights u_rights (
    .user_page_i (acc_user_i),
    .rw_i        (acc_rw_i),
    .nx_i        (acc_nx_i),
    .user_mode_i (user_mode_i),
    .sap_i       (sap_i),
    .wp_i        (wp_i),
    .smep_i      (smep_i),
    .base_o      (base),
    .user_fault_o(user_fault)
  );

  pac_key #(.KEY_W(KEY_W)) u_key (
    .user_page_i(acc_user_i),
    .pke_i      (pke_i),
    .pks_i      (pks_i),
    .pkr_user_i (pkr_user_i),
    .pkr_sup_i  (pkr_sup_i),
    .pkey_i     (pkey_i),
    .user_mode_i(user_mode_i),
    .wp_i       (wp_i),
    .active_o   (key_active),
    .key_perm_o (kperm)
  );

  always_comb begin
    comb_perm = key_active ? (base & kperm) : base;
    walk_ok   = present_i && !rsvd_i;
    f_np      = !present_i;
    f_rs      = present_i && rsvd_i;
    f_uf      = walk_ok && user_fault;
    f_kd      = walk_ok && !user_fault && key_active && !perm_sel(kperm, access_i);
    f_pf      = walk_ok && !user_fault && !f_kd && !perm_sel(comb_perm, access_i);
    f_any     = f_np || f_rs || f_uf || f_kd || f_pf;
    // clean page: write right not cacheable unless this very access dirties it
    pw_d      = comb_perm.w && (dirty_i || access_i == ACC_WRITE);
  end

  pac_errcode u_err (
    .fault_i    (f_any),
    .prot_i     (f_uf || f_kd || f_pf),
    .rsvd_i     (f_rs),
    .pk_i       (f_kd),
    .access_i   (access_i),
    .user_mode_i(user_mode_i),
    .nxe_i      (nxe_i),
    .smep_i     (smep_i),
    .err_o      (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      perm_r_o   <= 1'b0;
      perm_w_o   <= 1'b0;
      perm_x_o   <= 1'b0;
      pass_o     <= 1'b0;
      fault_o    <= 1'b0;
      err_code_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        perm_r_o   <= walk_ok && comb_perm.r;
        perm_w_o   <= walk_ok && pw_d;
        perm_x_o   <= walk_ok && comb_perm.x;
        pass_o     <= !f_any;
        fault_o    <= f_any;
        err_code_o <= err_d;
      end
    end
  end
endmodule

// File: rtl/pac_checker_sva.sv
module pac_checker_sva
  import pac_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             present_i,
  input logic             rsvd_i,
  input logic             acc_user_i,
  input logic             acc_nx_i,
  input logic             user_mode_i,
  input logic             sap_i,
  input logic             valid_o,
  input logic             perm_r_o,
  input logic             perm_w_o,
  input logic             perm_x_o,
  input logic             pass_o,
  input logic             fault_o,
  input logic [ERR_W-1:0] err_code_o
);
  p_sap_noread_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sap_i && acc_user_i) |=> (!perm_r_o && !perm_w_o));

  p_nx_noexec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_nx_i) |=> !perm_x_o);

  p_user_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && present_i && !rsvd_i && user_mode_i && !acc_user_i)
      |=> (fault_o && err_code_o[ERR_P] && err_code_o[ERR_U]));

  p_pass_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (err_code_o == '0));

  p_rsvd_has_p_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o[ERR_RSVD] |-> (err_code_o[ERR_P] && fault_o));

  p_pk_has_p_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o[ERR_PK] |-> (err_code_o[ERR_P] && !err_code_o[ERR_RSVD]));

  p_np_norights_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !present_i) |=> (!perm_r_o && !perm_w_o && !perm_x_o && fault_o
                                 && !err_code_o[ERR_P]));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pass_o) && $stable(err_code_o) && !valid_o));
endmodule

bind pac_checker pac_checker_sva u_sva (.*);

// File: tb/sim_pac_checker.sv
module sim_pac_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 0, present_i = 0, rsvd_i = 0;
  logic        acc_user_i = 0, acc_rw_i = 0, acc_nx_i = 0, dirty_i = 0;
  logic [3:0]  pkey_i = 0;
  logic [1:0]  access_i = 0;
  logic        user_mode_i = 0, sap_i = 0, wp_i = 0, smep_i = 0, nxe_i = 0;
  logic        pke_i = 0, pks_i = 0;
  logic [31:0] pkr_user_i = 0, pkr_sup_i = 0;
  logic        valid_o, perm_r_o, perm_w_o, perm_x_o, pass_o, fault_o;
  logic [5:0]  err_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pac_checker u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {r,w,x}, pass, err from the requirement text
  logic [2:0] e_perm;
  logic       e_pass;
  logic [5:0] e_err;

  task automatic model();
    logic r, w, x, kr, kw, ka, ad, wd, sel_k, sel_c, ok, uf, kd, pf, prot;
    logic [31:0] kreg;
    r = !(sap_i && acc_user_i);                                   // R2
    w = r && (acc_rw_i || (!user_mode_i && !wp_i));               // R3
    x = !acc_nx_i && (!smep_i || !acc_user_i || user_mode_i);     // R5
    kreg = acc_user_i ? (pke_i ? pkr_user_i : 0) : (pks_i ? pkr_sup_i : 0); // R6
    ka = (kreg != 0);
    ad = kreg[pkey_i * 2];
    wd = kreg[pkey_i * 2 + 1];
    kr = !ad;                                                     // R7
    kw = !ad && !(wd && (user_mode_i || wp_i));
    if (ka) begin r = r && kr; w = w && kw; end
    sel_k = (access_i == 1) ? kw : (access_i == 2) ? 1'b1 : kr;   // R8
    sel_c = (access_i == 1) ? w : (access_i == 2) ? x : r;
    ok = present_i && !rsvd_i;
    uf = ok && user_mode_i && !acc_user_i;
    kd = ok && !uf && ka && !sel_k;
    pf = ok && !uf && !kd && !sel_c;
    prot = uf || kd || pf;
    e_pass = ok && !prot;
    e_perm = ok ? {r, w && (dirty_i || access_i == 1), x} : 3'b000; // R4 R11
    e_err = 0;
    if (!e_pass) begin                                            // R9 R10
      e_err[0] = prot || (present_i && rsvd_i);
      e_err[1] = (access_i == 1);
      e_err[2] = user_mode_i;
      e_err[3] = present_i && rsvd_i;
      e_err[4] = (access_i == 2) && (nxe_i || smep_i);
      e_err[5] = kd;
    end
  endtask

  task automatic check_all(input string tag);
    model();
    chk({tag, " R2 R3 R4 R5 R7 R11 rights"}, {29'd0, perm_r_o, perm_w_o, perm_x_o}, {29'd0, e_perm});
    chk({tag, " R8 pass"}, {30'd0, pass_o, fault_o}, {30'd0, e_pass, !e_pass});
    chk({tag, " R9 R10 err"}, {26'd0, err_code_o}, {26'd0, e_err});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] hold_err;
    logic       hold_pass;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {25'd0, valid_o, perm_r_o, perm_w_o, perm_x_o, pass_o, fault_o, |err_code_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {25'd0, valid_o, perm_r_o, perm_w_o, perm_x_o, pass_o, fault_o, |err_code_o}, 32'd0);

    for (int i = 0; i < 16384; i++) begin
      logic [31:0] h;
      h = (i * 32'h9E37_79B1) ^ 32'h5A3C_96E1;
      acc_user_i  = i[0];  acc_rw_i = i[1]; acc_nx_i = i[2]; dirty_i = i[3];
      access_i    = i[5:4];
      user_mode_i = i[6];  sap_i = i[7];  wp_i = i[8];  smep_i = i[9];
      nxe_i       = i[10]; pke_i = i[11]; pks_i = i[12];
      pkey_i      = h[7:4] ^ {i[13], i[2:0]};
      pkr_user_i  = (i % 11 == 0) ? 32'd0 : {h[15:0], h[31:16]} ^ (i * 32'h0101);
      pkr_sup_i   = (i % 13 == 0) ? 32'd0 : h ^ {i[15:0], 16'hC3A5};
      present_i   = (i % 37 != 5);
      rsvd_i      = (i % 41 == 7);
      valid_i     = 1'b1;
      @(negedge clk_i);
      check_all("sweep");
      chk("R12 valid", {31'd0, valid_o}, 32'd1);
    end

    // R12: idle cycle with changed inputs leaves results untouched
    hold_err  = e_err;
    hold_pass = e_pass;
    valid_i   = 1'b0;
    present_i = 1'b0;
    access_i  = 2'd1;
    user_mode_i = ~user_mode_i;
    @(negedge clk_i);
    chk("R12 hold err", {26'd0, err_code_o}, {26'd0, hold_err});
    chk("R12 hold pass", {31'd0, pass_o}, {31'd0, hold_pass});
    chk("R12 valid low", {31'd0, valid_o}, 32'd0);

    // R4 directed: clean writable page, write passes, read not cacheable-write
    valid_i = 1; present_i = 1; rsvd_i = 0; acc_user_i = 1; acc_rw_i = 1; acc_nx_i = 0;
    dirty_i = 0; user_mode_i = 1; sap_i = 0; wp_i = 1; smep_i = 0; nxe_i = 0;
    pke_i = 0; pks_i = 0; access_i = 2'd1;
    @(negedge clk_i);
    chk("R4 clean write passes", {30'd0, pass_o, perm_w_o}, 32'd3);
    access_i = 2'd0;
    @(negedge clk_i);
    chk("R4 clean read no w", {30'd0, pass_o, perm_w_o}, 32'd2);

    // R6 directed: key enable set but register zero skips key check
    pke_i = 1; pkr_user_i = 32'd0; pkey_i = 4'd9; access_i = 2'd1;
    @(negedge clk_i);
    chk("R6 zero key reg", {26'd0, err_code_o}, 32'd0);
    // R10 directed: write-disable on key 9 for user write
    pkr_user_i = 32'h1 << 19;
    @(negedge clk_i);
    chk("R10 wd fault", {26'd0, err_code_o}, 32'h27);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule